// File: doc/BRIEF.md
# Spread-Spectrum Filterless PWM Modulator

This block turns a signed 16-bit audio sample into two pulse-width-modulated logic signals that drive the two halves of a bridge-tied, filterless class-D output stage. With a zero sample, both halves switch together at half duty, so the load sees no net voltage. A signal moves the two duties away from half in opposite directions.

Each carrier period is counted on the system clock. With the default 48 MHz clock, the nominal period is 160 counts (300 kHz). When spreading is enabled, each new period is drawn from a pseudo-random sequence in the range 112 to 208 counts (±30 %). The duty thresholds are scaled to the period that is about to run. The sample and the period are taken only at the start of a period. Dropping the output enable parks both outputs low and stops the carrier. When the enable returns, a fresh period begins at once.

Top module: `spread_pwm_mod`

## Requirements
- R1: While reset is asserted, both outputs are low, whatever the other inputs do.
- R2: With a zero sample, both outputs are high for exactly floor(P/2) cycles of a P-cycle period. The two waveforms are identical.
- R3: For a latched sample s (two's complement) and period P, let off = floor(s·P / 2^17). The positive output is high for floor(P/2)+off cycles and the negative output for floor(P/2)−off cycles. Each count is clamped to 1..P−1. A positive sample therefore widens the positive output, and a negative sample widens the negative output.
- R4: Every period starts with both outputs high in its first cycle. Each output stays high for its count and then stays low for the rest of the period.
- R5: When spreading is off at a period start, that period lasts 160 cycles.
- R6: When spreading is on at a period start, that period lasts 112 + (L mod 97) cycles, where L is the current 16-bit generator state. Every period therefore lies in 112..208.
- R7: The generator is loaded with 16'hACE1 at reset. It advances once at every period start, whether spreading is on or off. The new bit, the XOR of bits 15, 14, 12 and 3, is shifted in at bit 0.
- R8: The sample and the period are captured only at a period start. Sample changes inside a period do not alter that period's duties.
- R9: At a clock edge that sees the enable low, both outputs go low and stay low while it is low. The first edge that sees the enable high again starts a new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock (48 MHz nominal) |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Output enable; low parks both outputs low |
| spread_en | input | 1 | Selects randomized carrier periods |
| sample | input | 16 | Signed audio sample |
| out_p | output | 1 | Positive half-bridge drive |
| out_n | output | 1 | Negative half-bridge drive |

## Verification
The embedded properties check the following on every cycle:
- the period register stays within its range;
- a fixed period is used when spreading is off;
- the latched sample holds between period starts;
- a zero sample gives equal thresholds, and a signed sample skews the thresholds in the right direction;
- both outputs rise together at a period start;
- both outputs go low after the enable drops.

Only the bench scenarios can show the exact high-time counts for each sample and period and the exact order of spread periods produced by the generator. They also show that changes made mid-period are deferred, and that re-enabling restarts the carrier on the first edge. For this, the bench measures every period and both pulse widths at the pins while it sweeps the sample range with spreading off and on.

// File: rtl/spread_pwm_pkg.sv
package spread_pwm_pkg;
  localparam int GEN_W = 16;

  // One step of the maximal-length generator: taps 16,15,13,4
  function automatic logic [GEN_W-1:0] gen_step(input logic [GEN_W-1:0] s);
    logic fb;
    fb = s[15] ^ s[14] ^ s[12] ^ s[3];
    return {s[GEN_W-2:0], fb};
  endfunction
endpackage

// File: rtl/spread_lfsr.sv
module spread_lfsr
  import spread_pwm_pkg::*;
#(
  parameter logic [GEN_W-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [GEN_W-1:0] state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   state <= SEED;
    else if (adv) state <= gen_step(state);
  end

  // R7: a maximal-length sequence never reaches the all-zero state
  a_r7_never_zero: assert property (@(posedge clk) disable iff (!rst_n) state != '0);
endmodule

// File: rtl/pwm_carrier.sv
module pwm_carrier
  import spread_pwm_pkg::*;
#(
  parameter int PER_NOM = 160,
  parameter int PER_MIN = 112,
  parameter int PER_MAX = 208,
  parameter int CNT_W   = $clog2(PER_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             spread_en,
  input  logic [GEN_W-1:0] gen_state,
  output logic             run,
  output logic             bnd,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] per_nx
);
  localparam int SPAN = PER_MAX - PER_MIN + 1;
  localparam logic [CNT_W-1:0] P_NOM = CNT_W'(PER_NOM);
  localparam logic [CNT_W-1:0] P_MIN = CNT_W'(PER_MIN);
  localparam logic [CNT_W-1:0] P_MAX = CNT_W'(PER_MAX);

  logic [CNT_W-1:0] per_q;
  logic             wrap;

  function automatic logic [CNT_W-1:0] pick_period(input logic [GEN_W-1:0] l);
    logic [GEN_W-1:0] m;
    m = l % GEN_W'(SPAN);
    return P_MIN + CNT_W'(m);
  endfunction

  assign per_nx = spread_en ? pick_period(gen_state) : P_NOM;
  assign wrap   = run && (cnt == per_q - 1'b1);
  assign bnd    = en && (!run || wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      cnt   <= '0;
      per_q <= P_NOM;
    end else if (!en) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (bnd) begin
      run   <= 1'b1;
      cnt   <= '0;
      per_q <= per_nx;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r6_period_range: assert property (@(posedge clk) disable iff (!rst_n)
    per_q >= P_MIN && per_q <= P_MAX);
  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt < per_q);
  a_r5_fixed_period: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd && !spread_en) |=> per_q == P_NOM);
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare #(
  parameter int SAMP_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     run,
  input  logic                     bnd,
  input  logic [CNT_W-1:0]         cnt,
  input  logic [CNT_W-1:0]         per_nx,
  input  logic signed [SAMP_W-1:0] sample,
  output logic                     out_p,
  output logic                     out_n
);
  localparam int PW    = SAMP_W + CNT_W + 1;
  localparam int SHIFT = SAMP_W + 1;

  logic signed [SAMP_W-1:0] samp_q;
  logic [CNT_W-1:0]         thr_p, thr_n;

  // High-time count for one output, clamped to 1..per-1
  function automatic logic [CNT_W-1:0] high_count(
    input logic [CNT_W-1:0] per, input logic signed [SAMP_W-1:0] s, input logic pos);
    logic signed [PW-1:0] prod, off, half, t, lim;
    prod = s * $signed({1'b0, per});
    off  = prod >>> SHIFT;
    half = $signed({{(SAMP_W+1){1'b0}}, per >> 1});
    lim  = $signed({{(SAMP_W+1){1'b0}}, per}) - 1;
    t    = pos ? half + off : half - off;
    if (t < 1)        t = 1;
    else if (t > lim) t = lim;
    return t[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= '0;
      thr_p  <= '0;
      thr_n  <= '0;
    end else if (bnd) begin
      samp_q <= sample;
      thr_p  <= high_count(per_nx, sample, 1'b1);
      thr_n  <= high_count(per_nx, sample, 1'b0);
    end
  end

  assign out_p = run && (cnt < thr_p);
  assign out_n = run && (cnt < thr_n);

  a_r8_sample_held: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> $stable(samp_q));
  a_r2_zero_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (run && samp_q == '0) |-> thr_p == thr_n);
  a_r3_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    (run && samp_q > 0) |-> thr_p >= thr_n);
endmodule

// File: rtl/spread_pwm_mod.sv
module spread_pwm_mod
  import spread_pwm_pkg::*;
#(
  parameter int SAMP_W  = 16,
  parameter int PER_NOM = 160,
  parameter int PER_MIN = 112,
  parameter int PER_MAX = 208,
  parameter logic [GEN_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              spread_en,
  input  logic [SAMP_W-1:0] sample,
  output logic              out_p,
  output logic              out_n
);
  localparam int CNT_W = $clog2(PER_MAX + 1);

  logic             run, bnd;
  logic [CNT_W-1:0] cnt, per_nx;
  logic [GEN_W-1:0] gen_state;

  spread_lfsr #(.SEED(SEED)) u_gen (
    .clk(clk), .rst_n(rst_n), .adv(bnd), .state(gen_state));

  pwm_carrier #(.PER_NOM(PER_NOM), .PER_MIN(PER_MIN), .PER_MAX(PER_MAX), .CNT_W(CNT_W)) u_car (
    .clk(clk), .rst_n(rst_n), .en(en), .spread_en(spread_en), .gen_state(gen_state),
    .run(run), .bnd(bnd), .cnt(cnt), .per_nx(per_nx));

  pwm_compare #(.SAMP_W(SAMP_W), .CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .run(run), .bnd(bnd), .cnt(cnt), .per_nx(per_nx),
    .sample($signed(sample)), .out_p(out_p), .out_n(out_n));

  a_r9_park_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!out_p && !out_n));
  a_r4_start_high: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |=> (out_p && out_n));
  a_r1_reset_low: assert final (rst_n || (!out_p && !out_n));
endmodule

// File: tb/sim_spread_pwm_mod.sv
module sim_spread_pwm_mod;
  localparam time CLK_T = 20ns;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, spread_en = 1'b0;
  logic [15:0] sample = '0;
  logic out_p, out_n;

  int n_tests = 0, n_fail = 0, cycles = 0;
  logic [15:0] gen = 16'hACE1;
  bit   open_per = 0, prev_p = 0, prev_en = 0, exp_rise = 0;
  int   len = 0, hp = 0, hn = 0, e_per = 0, e_tp = 0, e_tn = 0, e_spr = 0;
  int   smin = 1000, smax = 0;

  spread_pwm_mod u0 (.clk(clk), .rst_n(rst_n), .en(en), .spread_en(spread_en),
    .sample(sample), .out_p(out_p), .out_n(out_n));

  always #(CLK_T/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int thr(input int per, input int s, input bit pos);
    int off, t;
    off = (s * per) >>> 17;
    t = pos ? per / 2 + off : per / 2 - off;
    if (t < 1) t = 1;
    if (t > per - 1) t = per - 1;
    return t;
  endfunction

  function automatic logic [15:0] step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[14] ^ s[12] ^ s[3]};
  endfunction

  task automatic close_period();
    if (open_per) begin
      chk(len == e_per, e_spr ? "R6 period" : "R5 period", len, e_per);
      chk(hp == e_tp, "R3 p high", hp, e_tp);
      chk(hn == e_tn, "R3 n high", hn, e_tn);
    end
  endtask

  // Monitor: a quarter period after each rising edge
  always @(posedge clk) begin
    #(CLK_T/4);
    cycles++;
    if (!rst_n) begin
      chk(!out_p && !out_n, "R1 reset", int'({out_p, out_n}), 0);
    end else if (!en) begin
      chk(!out_p && !out_n, "R9 parked", int'({out_p, out_n}), 0);
      open_per = 0;
    end else begin
      if (!prev_en) chk(out_p && !prev_p, "R9 restart", int'(out_p), 1);
      if (out_p && !prev_p) begin
        close_period();
        chk(out_n, "R4 in phase", int'(out_n), 1);
        e_spr = spread_en;
        e_per = spread_en ? 112 + int'(gen) % 97 : 160;
        if (spread_en) begin
          if (e_per < smin) smin = e_per;
          if (e_per > smax) smax = e_per;
        end
        gen   = step(gen);  // R7: one step per period start
        e_tp  = thr(e_per, int'($signed(sample)), 1'b1);
        e_tn  = thr(e_per, int'($signed(sample)), 1'b0);
        if (sample == 16'd0) chk(e_tp == e_per / 2, "R2 zero half", e_tp, e_per / 2);
        open_per = 1;
        len = 1; hp = 1; hn = int'(out_n);
      end else if (open_per) begin
        len++;
        hp += int'(out_p);
        hn += int'(out_n);
        // R4: once low, an output stays low until the period ends
        if (out_p && len > e_tp) chk(0, "R4 p shape", len, e_tp);
        if (out_n && len > e_tn) chk(0, "R4 n shape", len, e_tn);
        if (sample == 16'd0 && e_tp == e_tn) chk(out_p == out_n, "R2 identical", int'(out_p), int'(out_n));
      end
    end
    prev_p  = out_p;
    prev_en = rst_n && en;
  end

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sweep the sample range; each value is held an irregular number of cycles (R8)
  task automatic sweep();
    for (int k = 0; k < 70; k++) begin
      int s;
      case (k)
        64: s = 0;
        65: s = 32767;
        66: s = -32768;
        67: s = 1;
        68: s = -1;
        69: s = 0;
        default: s = -32768 + k * 1040;
      endcase
      sample = 16'(s);
      hold(150 + (k * 37) % 41);
    end
  endtask

  initial begin
    en = 1'b1;  // R1: outputs stay low under reset even with the enable high
    hold(5);
    en = 1'b0;
    hold(2);
    rst_n = 1'b1;
    hold(5);
    en = 1'b1;
    sweep();  // R5, R3, R2
    spread_en = 1'b1;
    sweep();  // R6, R7
    // R9: the enable drops mid-period, then returns
    hold(37);
    en = 1'b0;
    hold(9);
    en = 1'b1;
    sample = 16'd20000;
    hold(300);
    spread_en = 1'b0;
    hold(200);
    spread_en = 1'b1;
    // Long spread run with mid-period sample changes (R8)
    for (int k = 0; k < 120; k++) begin
      sample = 16'((k * 7919) % 65536);
      hold(97 + (k * 53) % 120);
    end
    en = 1'b0;
    hold(3);
    chk(smin >= 112 && smax <= 208, "R6 range", smax, 208);
    chk(smax - smin > 50, "R6 spread width", smax - smin, 51);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule